// File: doc/BRIEF.md
# Clock group generation controller

This block runs one clock group of an on-chip clock generation unit, modelled with clock-enable pulses on a single fast clock. Each base source is represented by a one-cycle tick input. The group picks one source and moves between sources without ever passing a partial or doubled tick. The selected tick stream feeds several fractional dividers, each of which produces a thinner pulse stream at an average rate of N/M of the base rate.

Every downstream function owns a small configuration register. That register names the divider the function draws from, and sets a software enable and an automatic mode. In automatic mode the function's gate follows an external event line after synchronization, and the software enable has no effect. A gate only changes state on a clock edge where the function's chosen divider is not ticking, so a pulse is never cut off.

Configuration is written through a simple write port. Register 0 is the source select. Registers 1 to NDIV hold the divider ratios. The registers after them hold the per-function settings.

Top module: `clkgrp_ctrl`

## Requirements
- R1: After reset, source 0 is selected, every divider runs at ratio 1/1 and every function gate is open, so each `fn_tick` bit equals `grp_tick`, which equals `src_tick[0]`.
- R2: `grp_tick` only ever carries ticks of one source at a time. A write to register 0 with a value of NSRC or more is ignored, as is a write that names the source already selected.
- R3: On a source change, the old source stays active up to and including its next tick and is then dropped. The new source is enabled only after that. Of the new source's ticks that fall in later cycles, the first SYNC_STAGES+1 (three by default) are swallowed, and the following ones pass.
- R4: Divider d is set by writing register 1+d with N in bits [FW-1:0] and M in bits [2*FW-1:FW]. The write clears its accumulator. On each base tick the divider adds N, and when the sum reaches M it subtracts M and passes that base tick, giving N pulses per M base ticks.
- R5: A divider write with N = 0 or N > M is ignored, and the previous ratio and accumulator are kept.
- R6: Function f is configured at register 1+NDIV+f. Bits [DSW-1:0] select its divider, bit 8 is the software enable and bit 9 is the automatic mode. A write whose divider index is NDIV or more is ignored as a whole. An open gate passes exactly the selected divider's pulses to `fn_tick[f]`.
- R7: With the automatic mode clear and the software enable clear, the function receives no ticks.
- R8: With the automatic mode set, the gate follows `evt_in[f]` through a SYNC_STAGES-flop synchronizer, and the software enable is ignored.
- R9: A function gate changes state only at a clock edge where its selected divider is not ticking in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock on which all tick inputs are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | NSRC | One-cycle tick per base source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CAW | Configuration register index |
| cfg_wdata | input | 2*FW | Configuration write data |
| evt_in | input | NFUNC | Per-function wake/sleep event, asynchronous |
| grp_tick | output | 1 | Selected base tick |
| fn_tick | output | NFUNC | Gated, divided tick per function |

## Verification
`grp_tick`, the divider pulses and `fn_tick` are combinational in the current tick inputs. They are therefore due in the same cycle as a source tick, while any configuration write acts from the edge that captures it. An event change reaches the gate register on the third edge after the event is driven, and later still if the selected divider is ticking at that edge. A source change takes a data-dependent number of cycles set by the tick spacing of both sources. The bench drives inputs at the falling edge, samples outputs 1 ns later, and advances its behavioural model at the rising edge, so every cycle's outputs are compared against the model. Directed window counts then check each ratio, gate and switch result once the latencies above have passed.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;
   localparam int unsigned REG_SRC_SEL  = 0;
   localparam int unsigned REG_DIV_BASE = 1;
   localparam int unsigned FN_EN_BIT    = 8;
   localparam int unsigned FN_AUTO_BIT  = 9;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/clkgrp_src_mux.sv
module clkgrp_src_mux #(
   parameter int unsigned NSRC        = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SW         = clkgrp_pkg::idx_w(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_tick,
   input  logic            sel_we,
   input  logic [SW-1:0]   sel_wdata,
   output logic [NSRC-1:0] src_on,
   output logic            grp_tick
);
   logic [SW-1:0] req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req_q <= '0;
      else if (sel_we) req_q <= sel_wdata;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic                   on_r;
      logic [SYNC_STAGES-1:0] sync_r;
      logic                   others_on;
      logic                   want;

      always_comb begin
         others_on = 1'b0;
         for (int j = 0; j < NSRC; j++)
            if (j != i) others_on = others_on | src_on[j];
      end
      assign want = (req_q == SW'(i)) && !others_on;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            on_r   <= (i == 0);
            sync_r <= (i == 0) ? '1 : '0;
         end else begin
            if (!want)         sync_r <= '0;
            else if (src_tick[i]) sync_r <= {sync_r[SYNC_STAGES-2:0], 1'b1};
            if (src_tick[i]) begin
               if (req_q != SW'(i))                   on_r <= 1'b0;
               else if (want && sync_r[SYNC_STAGES-1]) on_r <= 1'b1;
            end
         end
      end
      assign src_on[i] = on_r;
   end

   assign grp_tick = |(src_tick & src_on);
endmodule

// File: rtl/clkgrp_frac_div.sv
module clkgrp_frac_div #(
   parameter int unsigned FW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_tick,
   input  logic          wr_en,
   input  logic [FW-1:0] wr_num,
   input  logic [FW-1:0] wr_den,
   output logic          div_tick
);
   logic [FW-1:0] num_q, den_q, acc_q;
   logic [FW:0]   sum;
   logic          hit, wr_ok;

   assign sum      = {1'b0, acc_q} + {1'b0, num_q};
   assign hit      = sum >= {1'b0, den_q};
   assign div_tick = base_tick && hit;
   assign wr_ok    = wr_en && (wr_num != '0) && (wr_num <= wr_den);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q <= FW'(1);
         den_q <= FW'(1);
         acc_q <= '0;
      end else if (wr_ok) begin
         num_q <= wr_num;
         den_q <= wr_den;
         acc_q <= '0;
      end else if (base_tick) begin
         if (hit) acc_q <= FW'(sum - {1'b0, den_q});
         else     acc_q <= sum[FW-1:0];
      end
   end
endmodule

// File: rtl/clkgrp_fn_gate.sv
module clkgrp_fn_gate #(
   parameter int unsigned NDIV        = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DSW        = clkgrp_pkg::idx_w(NDIV)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NDIV-1:0] div_tick,
   input  logic            cfg_we,
   input  logic [DSW-1:0]  cfg_sel,
   input  logic            cfg_en,
   input  logic            cfg_auto,
   input  logic            evt_in,
   output logic            sel_tick,
   output logic            gate_o,
   output logic            fn_tick
);
   logic [DSW-1:0]         sel_q;
   logic                   en_q, auto_q, gate_q;
   logic [SYNC_STAGES-1:0] evt_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         en_q   <= 1'b1;
         auto_q <= 1'b0;
      end else if (cfg_we && ({1'b0, cfg_sel} < (DSW+1)'(NDIV))) begin
         sel_q  <= cfg_sel;
         en_q   <= cfg_en;
         auto_q <= cfg_auto;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_sync <= '0;
      else        evt_sync <= {evt_sync[SYNC_STAGES-2:0], evt_in};
   end

   if (NDIV == 1) begin : g_one
      assign sel_tick = div_tick[0];
   end else begin : g_many
      assign sel_tick = div_tick[sel_q];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gate_q <= 1'b1;
      else if (!sel_tick) gate_q <= auto_q ? evt_sync[SYNC_STAGES-1] : en_q;
   end

   assign gate_o  = gate_q;
   assign fn_tick = sel_tick && gate_q;
endmodule

// File: rtl/clkgrp_ctrl.sv
module clkgrp_ctrl import clkgrp_pkg::*; #(
   parameter int unsigned NSRC        = 3,
   parameter int unsigned NDIV        = 3,
   parameter int unsigned NFUNC       = 4,
   parameter int unsigned FW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CAW         = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_tick,
   input  logic             cfg_we,
   input  logic [CAW-1:0]   cfg_addr,
   input  logic [2*FW-1:0]  cfg_wdata,
   input  logic [NFUNC-1:0] evt_in,
   output logic             grp_tick,
   output logic [NFUNC-1:0] fn_tick
);
   localparam int unsigned SW      = idx_w(NSRC);
   localparam int unsigned DSW     = idx_w(NDIV);
   localparam int unsigned WDW     = 2 * FW;
   localparam int unsigned FN_BASE = REG_DIV_BASE + NDIV;
   localparam int unsigned NREGS   = FN_BASE + NFUNC;

   if (NSRC < 2)                 begin : g_bad_nsrc  $error("NSRC must be at least 2");        end
   if (NDIV < 1)                 begin : g_bad_ndiv  $error("NDIV must be at least 1");        end
   if (NFUNC < 1)                begin : g_bad_nfunc $error("NFUNC must be at least 1");       end
   if (SYNC_STAGES < 2)          begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (NREGS > (1 << CAW))       begin : g_bad_caw   $error("CAW too small for register set"); end
   if (DSW > FN_EN_BIT)          begin : g_bad_dsw   $error("divider index overlaps flags");   end
   if (WDW < FN_AUTO_BIT + 1)    begin : g_bad_fw    $error("FW too small for function flags"); end

   logic [NSRC-1:0]  src_on;
   logic [NDIV-1:0]  div_tick;
   logic [NFUNC-1:0] fn_sel_tick;
   logic [NFUNC-1:0] fn_gate;
   logic             sel_we;

   assign sel_we = cfg_we && (cfg_addr == CAW'(REG_SRC_SEL)) && (cfg_wdata < WDW'(NSRC));

   clkgrp_src_mux #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_mux (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .sel_we(sel_we), .sel_wdata(cfg_wdata[SW-1:0]),
      .src_on(src_on), .grp_tick(grp_tick)
   );

   for (genvar d = 0; d < NDIV; d++) begin : g_div
      clkgrp_frac_div #(.FW(FW)) u_div (
         .clk(clk), .rst_n(rst_n), .base_tick(grp_tick),
         .wr_en(cfg_we && (cfg_addr == CAW'(REG_DIV_BASE + d))),
         .wr_num(cfg_wdata[FW-1:0]), .wr_den(cfg_wdata[2*FW-1:FW]),
         .div_tick(div_tick[d])
      );
   end

   for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      clkgrp_fn_gate #(.NDIV(NDIV), .SYNC_STAGES(SYNC_STAGES)) u_gate (
         .clk(clk), .rst_n(rst_n), .div_tick(div_tick),
         .cfg_we(cfg_we && (cfg_addr == CAW'(FN_BASE + f))),
         .cfg_sel(cfg_wdata[DSW-1:0]),
         .cfg_en(cfg_wdata[FN_EN_BIT]), .cfg_auto(cfg_wdata[FN_AUTO_BIT]),
         .evt_in(evt_in[f]),
         .sel_tick(fn_sel_tick[f]), .gate_o(fn_gate[f]), .fn_tick(fn_tick[f])
      );
   end
endmodule

// File: rtl/clkgrp_ctrl_chk.sv
module clkgrp_ctrl_chk #(
   parameter int unsigned NSRC  = 3,
   parameter int unsigned NDIV  = 3,
   parameter int unsigned NFUNC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NSRC-1:0]  src_on,
   input logic             grp_tick,
   input logic [NDIV-1:0]  div_tick,
   input logic [NFUNC-1:0] fn_tick,
   input logic [NFUNC-1:0] fn_sel_tick,
   input logic [NFUNC-1:0] fn_gate
);
   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_on)); // R2

   AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_on != '0 && $past(src_on) != '0) |-> (src_on == $past(src_on))); // R3

   for (genvar d = 0; d < NDIV; d++) begin : g_d
      AST_DIV_UNDER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
         div_tick[d] |-> grp_tick); // R4
   end

   for (genvar f = 0; f < NFUNC; f++) begin : g_f
      AST_FN_FROM_DIVIDER: assert property (@(posedge clk) disable iff (!rst_n)
         fn_tick[f] |-> (|div_tick)); // R6
      AST_GATE_QUIET_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         (fn_gate[f] != $past(fn_gate[f])) |-> !$past(fn_sel_tick[f])); // R9
   end
endmodule

bind clkgrp_ctrl clkgrp_ctrl_chk #(.NSRC(NSRC), .NDIV(NDIV), .NFUNC(NFUNC)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_on(src_on), .grp_tick(grp_tick),
   .div_tick(div_tick), .fn_tick(fn_tick), .fn_sel_tick(fn_sel_tick), .fn_gate(fn_gate)
);

// File: tb/clkgrp_ctrl_test.sv
`timescale 1ns/1ps
module clkgrp_ctrl_test;
   localparam int NSRC = 3, NDIV = 3, NFUNC = 4, FW = 8, SYNC = 2, CAW = 4;
   localparam int FNB = 1 + NDIV;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NSRC-1:0]  src_tick = '0;
   logic             cfg_we = 1'b0;
   logic [CAW-1:0]   cfg_addr = '0;
   logic [2*FW-1:0]  cfg_wdata = '0;
   logic [NFUNC-1:0] evt_in = '0;
   logic             grp_tick;
   logic [NFUNC-1:0] fn_tick;

   always #4 clk = ~clk;

   clkgrp_ctrl #(.NSRC(NSRC), .NDIV(NDIV), .NFUNC(NFUNC), .FW(FW), .SYNC_STAGES(SYNC), .CAW(CAW)) uut (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .evt_in(evt_in), .grp_tick(grp_tick), .fn_tick(fn_tick));

   int checks = 0, errors = 0, cyc = 0;
   bit dense = 0, done = 0;
   int c_grp, c_src[NSRC], c_fn[NFUNC];

   // behavioural reference state
   int m_on[NSRC], m_sync[NSRC], m_req;
   int m_n[NDIV], m_m[NDIV], m_acc[NDIV];
   int m_sel[NFUNC], m_en[NFUNC], m_auto[NFUNC], m_e1[NFUNC], m_e2[NFUNC], m_gate[NFUNC];
   int e_grp, e_dt[NDIV], e_fn[NFUNC];

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < NSRC; s++) begin m_on[s] = (s == 0); m_sync[s] = (s == 0) ? SYNC : 0; end
      m_req = 0;
      for (int d = 0; d < NDIV; d++) begin m_n[d] = 1; m_m[d] = 1; m_acc[d] = 0; end
      for (int f = 0; f < NFUNC; f++) begin
         m_sel[f] = 0; m_en[f] = 1; m_auto[f] = 0; m_e1[f] = 0; m_e2[f] = 0; m_gate[f] = 1;
      end
   endtask

   task automatic model_eval();
      e_grp = 0;
      for (int s = 0; s < NSRC; s++) if (src_tick[s] && m_on[s] != 0) e_grp = 1;
      for (int d = 0; d < NDIV; d++) e_dt[d] = (e_grp != 0 && m_acc[d] + m_n[d] >= m_m[d]) ? 1 : 0;
      for (int f = 0; f < NFUNC; f++) e_fn[f] = (e_dt[m_sel[f]] != 0 && m_gate[f] != 0) ? 1 : 0;
   endtask

   task automatic model_update();
      int n_on[NSRC];
      int wd, num, den;
      wd = int'(cfg_wdata);
      for (int s = 0; s < NSRC; s++) begin
         int others, want;
         others = 0;
         for (int t = 0; t < NSRC; t++) if (t != s && m_on[t] != 0) others = 1;
         want = (m_req == s && others == 0) ? 1 : 0;
         n_on[s] = m_on[s];
         if (src_tick[s]) begin
            if (m_req != s) n_on[s] = 0;
            else if (want != 0 && m_sync[s] >= SYNC) n_on[s] = 1;
         end
         if (want == 0) m_sync[s] = 0;
         else if (src_tick[s] && m_sync[s] < SYNC) m_sync[s]++;
      end
      for (int s = 0; s < NSRC; s++) m_on[s] = n_on[s];
      if (cfg_we && cfg_addr == 0 && wd < NSRC) m_req = wd;
      num = wd & 8'hFF; den = (wd >> 8) & 8'hFF;
      for (int d = 0; d < NDIV; d++) begin
         if (cfg_we && cfg_addr == 1 + d && num != 0 && num <= den) begin
            m_n[d] = num; m_m[d] = den; m_acc[d] = 0;
         end else if (e_grp != 0) begin
            m_acc[d] = m_acc[d] + m_n[d];
            if (m_acc[d] >= m_m[d]) m_acc[d] -= m_m[d];
         end
      end
      for (int f = 0; f < NFUNC; f++) begin
         if (e_dt[m_sel[f]] == 0) m_gate[f] = (m_auto[f] != 0) ? m_e2[f] : m_en[f];
         m_e2[f] = m_e1[f]; m_e1[f] = evt_in[f];
         if (cfg_we && cfg_addr == FNB + f && (wd & 3) < NDIV) begin
            m_sel[f] = wd & 3; m_en[f] = (wd >> 8) & 1; m_auto[f] = (wd >> 9) & 1;
         end
      end
   endtask

   // one cycle: drive ticks at falling edge, compare 1 ns later, advance model at rising edge
   task automatic step();
      src_tick[0] = (cyc % 2 == 0);
      src_tick[1] = (cyc % 3 == 1);
      src_tick[2] = dense || (cyc % 5 == 3);
      #1;
      model_eval();
      check(int'(grp_tick) == e_grp, "R3", "grp_tick vs model", grp_tick, e_grp);
      for (int f = 0; f < NFUNC; f++)
         check(int'(fn_tick[f]) == e_fn[f], "R6,R9", $sformatf("fn_tick[%0d] vs model", f), fn_tick[f], e_fn[f]);
      c_grp += grp_tick;
      for (int s = 0; s < NSRC; s++) c_src[s] += src_tick[s];
      for (int f = 0; f < NFUNC; f++) c_fn[f] += fn_tick[f];
      @(posedge clk);
      model_update();
      cyc++;
      @(negedge clk);
   endtask

   task automatic clr();
      c_grp = 0;
      for (int s = 0; s < NSRC; s++) c_src[s] = 0;
      for (int f = 0; f < NFUNC; f++) c_fn[f] = 0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic run_base(input int k);
      for (int i = 0; i < 1000 && c_grp < k; i++) step();
   endtask

   task automatic wr(input int a, input int d);
      cfg_we = 1'b1; cfg_addr = CAW'(a); cfg_wdata = (2*FW)'(d);
      step();
      cfg_we = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      clr(); run(20);
      check(c_grp == c_src[0], "R1", "grp ticks equal source 0", c_grp, c_src[0]);
      for (int f = 0; f < NFUNC; f++)
         check(c_fn[f] == c_src[0], "R1", "fn ticks equal source 0", c_fn[f], c_src[0]);

      // R7: software disable
      wr(FNB + 2, 16'h0000); run(3);
      clr(); run(20);
      check(c_fn[2] == 0, "R7", "disabled function silent", c_fn[2], 0);

      // R4, R6: ratios 3/8 and 1/2
      wr(FNB + 1, 16'h0101);
      wr(1, 16'h0803); clr(); run_base(16);
      check(c_fn[0] == 6, "R4", "3/8 over 16 base ticks", c_fn[0], 6);
      wr(2, 16'h0201); clr(); run_base(16);
      check(c_fn[1] == 8, "R6", "fn1 on 1/2 divider", c_fn[1], 8);
      check(c_fn[0] == 6, "R4", "3/8 continues", c_fn[0], 6);

      // R5: invalid ratios ignored
      wr(1, 16'h0800); clr(); run_base(16);
      check(c_fn[0] == 6, "R5", "N=0 write ignored", c_fn[0], 6);
      wr(1, 16'h0809); clr(); run_base(16);
      check(c_fn[0] == 6, "R5", "N>M write ignored", c_fn[0], 6);

      // R6: out-of-range divider index ignored (fn1 stays on 1/2)
      wr(FNB + 1, 16'h0103); clr(); run_base(16);
      check(c_fn[1] == 8, "R6", "bad divider index ignored", c_fn[1], 8);

      // R8: automatic mode following event
      wr(FNB + 3, 16'h0202); evt_in[3] = 1'b0; run(6);
      clr(); run(20);
      check(c_fn[3] == 0, "R8", "auto, event low", c_fn[3], 0);
      evt_in[3] = 1'b1; run(6);
      clr(); run(20);
      check(c_fn[3] == c_grp, "R8", "auto, event high", c_fn[3], c_grp);
      wr(FNB + 3, 16'h0302); evt_in[3] = 1'b0; run(6);
      clr(); run(20);
      check(c_fn[3] == 0, "R8", "software enable ignored in auto", c_fn[3], 0);

      // R3, R2: source switch to 1, then invalid select
      wr(0, 1); run(40);
      clr(); run(30);
      check(c_grp == c_src[1], "R3", "switched to source 1", c_grp, c_src[1]);
      wr(0, 3); clr(); run(30);
      check(c_grp == c_src[1], "R2", "select 3 ignored", c_grp, c_src[1]);
      wr(0, 1); clr(); run(30);
      check(c_grp == c_src[1], "R2", "same select no effect", c_grp, c_src[1]);

      // R9: gate frozen while its divider ticks every cycle
      wr(0, 2); run(60);
      wr(FNB + 2, 16'h0102); run(12);
      dense = 1; run(3);
      wr(FNB + 2, 16'h0002);
      clr(); run(10);
      check(c_fn[2] == 10, "R9", "gate held while ticking", c_fn[2], 10);
      dense = 0; run(12);
      clr(); run(20);
      check(c_fn[2] == 0, "R9", "gate closes in a quiet cycle", c_fn[2], 0);

      // back to source 0
      wr(0, 0); run(40);
      clr(); run(30);
      check(c_grp == c_src[0], "R3", "switched back to source 0", c_grp, c_src[0]);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule